// File: doc/BRIEF.md
# Modulo Wake-Up Timer

This block is a memory-mapped up-counter meant to wake a system after a programmed delay. Software reaches four 32-bit registers over a simple single-cycle register bus: a status/control word, the live count, a terminal (modulo) value and a reload value. Counting is driven by an external fixed-frequency tick-enable input, which is divided by a power-of-two prescaler before it reaches the counter. A clock-select field in the control word either stops counting or routes the tick input to the prescaler.

The counter steps from the reload value up to the terminal value. On the next prescaled tick it returns to the reload value and raises a sticky overflow flag. The interrupt output is the overflow flag gated by an interrupt-enable bit. To make the flag fire N prescaled ticks after the counter starts from reload value 0, software sets the terminal value to N-1. Software clears the flag by writing 0 to its bit. If a clear and a new overflow fall in the same cycle, the new overflow wins, so no overflow is lost.

The register bus has no back-pressure. It is always ready, a write takes effect at the clock edge where `bus_sel` and `bus_wr` are high, and read data is valid in the same cycle as the address.

Top module: `wake_mod_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: Register map by byte offset (bits [3:2] of `bus_addr`): 0x0 control/status, 0x4 count, 0x8 terminal value, 0xC reload value. Read data is valid in the same cycle as the address.
- R3: The control word holds the prescale field in bits [2:0], the clock-select field in bits [4:3], the interrupt enable in bit 6 and the overflow flag in bit 7. All other bits read 0.
- R4: On each prescaled tick, if the count differs from the terminal value, the count increases by one.
- R5: On a prescaled tick where the count equals the terminal value, the count loads the reload value and the overflow flag sets.
- R6: A write of any data to the count register loads the count with the reload value. The written data is ignored.
- R7: The count, terminal and reload registers are 16 bits wide. Bits [31:16] read 0, and written data in those bits is ignored.
- R8: Only clock-select value 2 lets the counter advance. Values 0, 1 and 3 hold the count.
- R9: The prescale value P passes one prescaled tick per 2^P tick-input pulses. Any write to the control word restarts the divider, so the first prescaled tick after it needs a full 2^P pulses.
- R10: `irq_o` is high exactly when the overflow flag and the interrupt enable are both set. Clearing the enable drops `irq_o` and leaves the flag unchanged.
- R11: Writing 0 to bit 7 of the control word clears the overflow flag. Writing 1 to that bit does not set the flag.
- R12: If an overflow and a flag-clearing write occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Fixed-frequency tick enable, one pulse per tick |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the address cycle |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Two functions can fall in the same cycle: a terminal-value overflow and a software write that clears the overflow flag. The bench sets both the terminal and reload values to 0, so that every prescaled tick is an overflow. It then issues the flag-clearing control write in the one cycle where the tick input is pulsed. The result is judged by reading the control word and sampling `irq_o`: the flag and the interrupt must still be set. A second clear with no tick must then succeed.

// File: rtl/wmt_pkg.sv
package wmt_pkg;
  // Control-word field positions
  localparam int unsigned SC_PS_LSB   = 0;
  localparam int unsigned SC_CLKS_LSB = 3;
  localparam int unsigned SC_TOIE_BIT = 6;
  localparam int unsigned SC_TOF_BIT  = 7;

  // Clock-select code that routes the tick input to the prescaler
  localparam logic [1:0] CLKS_TICK = 2'd2;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_TERM  = 2'd2,
    REG_RELD  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/wmt_prescaler.sv
module wmt_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            restart_i,
  input  logic            tick_i,
  output logic            tick_o
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             div_end;

  // mask has the ps_i low bits set: the divider wraps at 2^ps_i - 1
  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < int'(ps_i));
    end
  end

  assign div_end = (div_q == mask);
  assign tick_o  = run_i && tick_i && div_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!run_i || restart_i) begin
      div_q <= '0;
    end else if (tick_i) begin
      div_q <= div_end ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/wmt_counter.sv
module wmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic             term_wr_i,
  input  logic             reld_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] term_o,
  output logic [CNT_W-1:0] reld_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, term_q, reld_q;
  logic             at_term;

  assign at_term = (cnt_q == term_q);
  // A load from the bus has priority over the tick and suppresses the wrap
  assign ovf_o   = tick_i && !cnt_wr_i && at_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr_i) begin
      cnt_q <= reld_q;
    end else if (tick_i) begin
      cnt_q <= at_term ? reld_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= '0;
      reld_q <= '0;
    end else begin
      if (term_wr_i) term_q <= wdata_i;
      if (reld_wr_i) reld_q <= wdata_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign term_o = term_q;
  assign reld_o = reld_q;
endmodule

// File: rtl/wmt_ctrl.sv
module wmt_ctrl #(
  parameter int PS_W   = 3,
  parameter int CLKS_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [PS_W-1:0]   ps_wd_i,
  input  logic [CLKS_W-1:0] clks_wd_i,
  input  logic              toie_wd_i,
  input  logic              tof_wd_i,
  input  logic              ovf_i,
  output logic [PS_W-1:0]   ps_o,
  output logic [CLKS_W-1:0] clks_o,
  output logic              toie_o,
  output logic              tof_o
);
  logic [PS_W-1:0]   ps_q;
  logic [CLKS_W-1:0] clks_q;
  logic              toie_q, tof_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= '0;
      clks_q <= '0;
      toie_q <= 1'b0;
    end else if (wr_i) begin
      ps_q   <= ps_wd_i;
      clks_q <= clks_wd_i;
      toie_q <= toie_wd_i;
    end
  end

  // Sticky flag: set beats a software clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tof_q <= 1'b0;
    end else if (ovf_i) begin
      tof_q <= 1'b1;
    end else if (wr_i && !tof_wd_i) begin
      tof_q <= 1'b0;
    end
  end

  assign ps_o   = ps_q;
  assign clks_o = clks_q;
  assign toie_o = toie_q;
  assign tof_o  = tof_q;
endmodule

// File: rtl/wake_mod_timer.sv
module wake_mod_timer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int CLKS_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  import wmt_pkg::*;

  reg_idx_e          idx;
  logic              wr_en;
  logic              ctrl_wr, cnt_wr, term_wr, reld_wr;
  logic [PS_W-1:0]   ps_q;
  logic [CLKS_W-1:0] clks_q;
  logic              toie_q, tof_q;
  logic              run, ptick, ovf;
  logic [CNT_W-1:0]  cnt_q, term_q, reld_q;

  assign idx     = reg_idx_e'(bus_addr[3:2]);
  assign wr_en   = bus_sel && bus_wr;
  assign ctrl_wr = wr_en && (idx == REG_CTRL);
  assign cnt_wr  = wr_en && (idx == REG_COUNT);
  assign term_wr = wr_en && (idx == REG_TERM);
  assign reld_wr = wr_en && (idx == REG_RELD);

  assign run = (clks_q == CLKS_W'(CLKS_TICK));

  wmt_ctrl #(.PS_W(PS_W), .CLKS_W(CLKS_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (ctrl_wr),
    .ps_wd_i   (bus_wdata[SC_PS_LSB +: PS_W]),
    .clks_wd_i (bus_wdata[SC_CLKS_LSB +: CLKS_W]),
    .toie_wd_i (bus_wdata[SC_TOIE_BIT]),
    .tof_wd_i  (bus_wdata[SC_TOF_BIT]),
    .ovf_i     (ovf),
    .ps_o      (ps_q),
    .clks_o    (clks_q),
    .toie_o    (toie_q),
    .tof_o     (tof_q)
  );

  wmt_prescaler #(.PS_W(PS_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .ps_i      (ps_q),
    .restart_i (ctrl_wr),
    .tick_i    (tick_i),
    .tick_o    (ptick)
  );

  wmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (ptick),
    .cnt_wr_i  (cnt_wr),
    .term_wr_i (term_wr),
    .reld_wr_i (reld_wr),
    .wdata_i   (bus_wdata[CNT_W-1:0]),
    .cnt_o     (cnt_q),
    .term_o    (term_q),
    .reld_o    (reld_q),
    .ovf_o     (ovf)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (idx)
      REG_CTRL: begin
        bus_rdata[SC_PS_LSB +: PS_W]     = ps_q;
        bus_rdata[SC_CLKS_LSB +: CLKS_W] = clks_q;
        bus_rdata[SC_TOIE_BIT]           = toie_q;
        bus_rdata[SC_TOF_BIT]            = tof_q;
      end
      REG_COUNT: bus_rdata[CNT_W-1:0] = cnt_q;
      REG_TERM:  bus_rdata[CNT_W-1:0] = term_q;
      REG_RELD:  bus_rdata[CNT_W-1:0] = reld_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq_o = tof_q && toie_q;
endmodule

// File: rtl/wmt_checker.sv
module wmt_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ptick,
  input logic              ovf,
  input logic              cnt_wr,
  input logic              ctrl_wr,
  input logic              wd_toie,
  input logic              wd_tof,
  input logic [1:0]        clks,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  term,
  input logic [CNT_W-1:0]  reld,
  input logic              tof,
  input logic [DATA_W-1:0] rdata,
  input logic              irq
);
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptick && !cnt_wr && cnt != term) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptick && !cnt_wr && cnt == term) |=> (cnt == $past(reld)) && tof);

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(reld)));

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:CNT_W] == '0);

  p_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clks != 2'd2) |-> !ptick);

  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wd_toie && wd_tof && tof) |=> (!irq && tof));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wd_tof && !ovf) |=> !tof);

  p_no_self_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tof && !ovf) |=> !tof);

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> tof);
endmodule

bind wake_mod_timer wmt_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ptick   (ptick),
  .ovf     (ovf),
  .cnt_wr  (cnt_wr),
  .ctrl_wr (ctrl_wr),
  .wd_toie (bus_wdata[6]),
  .wd_tof  (bus_wdata[7]),
  .clks    (clks_q),
  .cnt     (cnt_q),
  .term    (term_q),
  .reld    (reld_q),
  .tof     (tof_q),
  .rdata   (bus_rdata),
  .irq     (irq_o)
);

// File: tb/wake_mod_timer_tb.sv
module wake_mod_timer_tb;
  localparam int CLK_P = 10;
  localparam logic [3:0] A_CTRL = 4'h0, A_CNT = 4'h4, A_TERM = 4'h8, A_RELD = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic rd_active = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  wake_mod_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #(CLK_P/2) clk = ~clk;

  // Monitor: pops the expected item and compares a quarter period after the falling edge
  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    #(CLK_P/4);
    if (rd_active && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read 0x%08h expected 0x%08h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d, input logic with_tick);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_i = with_tick;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; tick_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    rd_active = 1'b1;
    @(posedge clk); #1;
    rd_active = 1'b0; bus_sel = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(posedge clk); #1; tick_i = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk); #(CLK_P/4);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s: irq_o %0b expected %0b", t, irq_o, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R2: reset values through the register map
    rd_chk(A_CTRL, 32'h0, "R1 ctrl after reset");
    rd_chk(A_CNT,  32'h0, "R1 count after reset");
    rd_chk(A_TERM, 32'h0, "R1 terminal after reset");
    rd_chk(A_RELD, 32'h0, "R1 reload after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // R7: upper halves dropped; R2: offsets select distinct registers
    wr_reg(A_TERM, 32'hFFFF_0005, 1'b0);
    wr_reg(A_RELD, 32'hABCD_0002, 1'b0);
    rd_chk(A_TERM, 32'h5, "R7 R2 terminal upper bits");
    rd_chk(A_RELD, 32'h2, "R7 R2 reload upper bits");

    // R8: clock-select 0, 1, 3 hold the count
    pulse(3);
    rd_chk(A_CNT, 32'h0, "R8 clks=0 holds");
    wr_reg(A_CTRL, 32'h08, 1'b0); pulse(3);
    rd_chk(A_CNT, 32'h0, "R8 clks=1 holds");
    wr_reg(A_CTRL, 32'h18, 1'b0); pulse(3);
    rd_chk(A_CNT, 32'h0, "R8 clks=3 holds");
    rd_chk(A_CTRL, 32'h18, "R3 ctrl field readback");

    // R6: any data written to the count loads the reload value
    wr_reg(A_CNT, 32'h0000_1234, 1'b0);
    rd_chk(A_CNT, 32'h2, "R6 count write loads reload");

    // R4: step by one per tick with prescale 0
    wr_reg(A_CTRL, 32'h10, 1'b0);
    pulse(2);
    rd_chk(A_CNT, 32'h4, "R4 count steps");
    pulse(1);
    rd_chk(A_CNT, 32'h5, "R4 count reaches terminal");
    rd_chk(A_CTRL, 32'h10, "R5 no flag before wrap");
    // R5: wrap to reload and set flag; R10: no irq while disabled
    pulse(1);
    rd_chk(A_CNT, 32'h2, "R5 wrap loads reload");
    rd_chk(A_CTRL, 32'h90, "R5 flag set on wrap");
    chk_irq(1'b0, "R10 irq masked");

    // R10: enable drives irq; clearing enable keeps flag
    wr_reg(A_CTRL, 32'hD0, 1'b0);
    chk_irq(1'b1, "R10 irq with enable");
    wr_reg(A_CTRL, 32'h90, 1'b0);
    rd_chk(A_CTRL, 32'h90, "R10 flag kept after disable");
    chk_irq(1'b0, "R10 irq dropped");

    // R11: write 0 clears, write 1 does not set
    wr_reg(A_CTRL, 32'h50, 1'b0);
    rd_chk(A_CTRL, 32'h50, "R11 clear by writing 0");
    chk_irq(1'b0, "R11 irq after clear");
    wr_reg(A_CTRL, 32'hD0, 1'b0);
    rd_chk(A_CTRL, 32'h50, "R11 writing 1 ignored");

    // R9: prescale 2 needs 4 pulses per step
    wr_reg(A_CTRL, 32'h52, 1'b0);
    pulse(3);
    rd_chk(A_CNT, 32'h2, "R9 ps=2 before 4th pulse");
    pulse(1);
    rd_chk(A_CNT, 32'h3, "R9 ps=2 after 4th pulse");
    pulse(4);
    rd_chk(A_CNT, 32'h4, "R9 ps=2 second step");
    // R9: prescale 7 needs 128 pulses, divider restarted by the write
    pulse(2);
    wr_reg(A_CTRL, 32'h57, 1'b0);
    pulse(127);
    rd_chk(A_CNT, 32'h4, "R9 ps=7 before 128th pulse");
    pulse(1);
    rd_chk(A_CNT, 32'h5, "R9 ps=7 after 128th pulse");

    // R12: overflow and clear in the same cycle
    wr_reg(A_TERM, 32'h0, 1'b0);
    wr_reg(A_RELD, 32'h0, 1'b0);
    wr_reg(A_CNT,  32'h55, 1'b0);
    wr_reg(A_CTRL, 32'h50, 1'b0);
    pulse(1);
    rd_chk(A_CNT, 32'h0, "R5 wrap at terminal 0");
    rd_chk(A_CTRL, 32'hD0, "R5 flag at terminal 0");
    wr_reg(A_CTRL, 32'h50, 1'b1);
    rd_chk(A_CTRL, 32'hD0, "R12 set wins over clear");
    chk_irq(1'b1, "R12 irq stays");
    wr_reg(A_CTRL, 32'h50, 1'b0);
    rd_chk(A_CTRL, 32'h50, "R12 later clear works");
    chk_irq(1'b0, "R12 irq low after clear");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule